// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It takes the fast clock that comes back from the oscillator and divides it by N = 64·B + A. Most counting is done by a short prescaler. The prescaler normally counts 64 input clocks. For the first A of its periods in each output cycle it counts 65 instead. An 11-bit B counter counts prescaler periods and closes the output cycle after B of them. At that point the block emits a pulse one input clock wide, which goes to the phase comparator.

The B and A values come from a configuration register. The block samples them only in the first input clock of each output cycle, so one output cycle never mixes two settings. A combinational flag reports a setting that is not allowed. Such a setting is never loaded, and the divider keeps the last legal ratio. After reset the held ratio is B = 3, A = 0 (N = 192), until a legal setting is sampled.

Top module: `swallow_divider`

## Requirements
- R1: While reset (rstN low) is asserted, divPulse is low.
- R2: For a legal setting, successive divPulse pulses are exactly 64·B + A input clocks apart.
- R3: divPulse is high for exactly one input clock per output cycle.
- R4: After reset is released with a legal setting, the first divPulse is high in the N-th clock following release, i.e. it is visible after the N-th rising edge.
- R5: cfgBad is high whenever B is below 3.
- R6: cfgBad is high whenever A is equal to or greater than B.
- R7: cfgBad is high whenever A is 64 or more. It is low when none of the conditions in R5, R6 and R7 hold.
- R8: A setting flagged by cfgBad is never loaded, and the divider keeps running at the last legal ratio.
- R9: Changes to B or A after the first clock of an output cycle do not affect that cycle. They take effect from the next cycle.
- R10: If no legal setting has been sampled since reset, the divider runs at B = 3, A = 0 (N = 192).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (the fast clock being divided) |
| rstN | input | 1 | Asynchronous active-low reset |
| bIn | input | 11 | B (main) counter setting, unsigned |
| aIn | input | 7 | A (swallow) count setting, unsigned |
| divPulse | output | 1 | One-clock pulse once per output cycle |
| cfgBad | output | 1 | High while bIn/aIn form a disallowed setting |

## Verification
Any fault in the prescaler count, the period index or the held ratio changes the spacing between two divPulse pulses. Such a fault therefore appears at the port by the end of the output cycle it affects, at most 64·2047 + 63 clocks later. Measuring exact pulse-to-pulse distances for several settings exposes a wrong modulus choice, an off-by-one in either counter, or a stale load. Changing inputs in the middle of a cycle, and applying settings that break each rule, shows whether loading happens only at the cycle start and only for legal values.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Strobes from the control side into the prescaler datapath
  typedef struct packed {
    logic swallow;   // current prescaler period counts one extra clock
    logic cycleEnd;  // this clock closes the output cycle
  } divStrobe_t;
endpackage

// File: rtl/swdiv_datapath.sv
module swdiv_datapath
  import swdiv_pkg::*;
#(
  parameter int PRE_LOG = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  output logic       pcTerm,
  output logic       pcZero,
  output logic       divPulse
);
  localparam int PC_W    = PRE_LOG + 1;
  localparam int BASE_M1 = (1 << PRE_LOG) - 1;
  localparam int ALT_M1  = (1 << PRE_LOG);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] lastVal;

  assign lastVal = strobe.swallow ? PC_W'(ALT_M1) : PC_W'(BASE_M1);
  assign pcTerm  = (pc == lastVal);
  assign pcZero  = (pc == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      divPulse <= 1'b0;
    end else begin
      pc       <= pcTerm ? '0 : pc + 1'b1;
      divPulse <= strobe.cycleEnd;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R2
  prescale_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pc <= PC_W'(ALT_M1));

  // R2
  prescale_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcTerm |=> pcZero);
endmodule

// File: rtl/swdiv_control.sv
module swdiv_control
  import swdiv_pkg::*;
#(
  parameter int B_W     = 11,
  parameter int A_W     = 7,
  parameter int PRE_LOG = 6,
  parameter int MIN_B   = 3,
  parameter int DEF_B   = 3,
  parameter int DEF_A   = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [B_W-1:0] bIn,
  input  logic [A_W-1:0] aIn,
  input  logic           pcTerm,
  input  logic           pcZero,
  output divStrobe_t     strobe,
  output logic           cfgBad
);
  localparam int PRE_VAL = 1 << PRE_LOG;

  logic [B_W-1:0] bAct;
  logic [A_W-1:0] aAct;
  logic [B_W-1:0] kCnt;
  logic [B_W-1:0] aWide;
  logic [B_W-1:0] aActWide;
  logic           atStart;
  logic           lastPeriod;
  logic           bLow, aNotBelowB, aTooBig;

  assign aWide      = B_W'(aIn);
  assign aActWide   = B_W'(aAct);
  assign bLow       = (bIn < B_W'(MIN_B));
  assign aNotBelowB = (aWide >= bIn);
  assign aTooBig    = (B_W'(aIn) >= B_W'(PRE_VAL));
  assign cfgBad     = bLow | aNotBelowB | aTooBig;

  assign atStart    = pcZero && (kCnt == '0);
  assign lastPeriod = (kCnt == bAct - 1'b1);

  always_comb begin
    strobe          = '0;
    strobe.swallow  = (kCnt < aActWide);
    strobe.cycleEnd = pcTerm && lastPeriod;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bAct <= B_W'(DEF_B);
      aAct <= A_W'(DEF_A);
    end else if (atStart && !cfgBad) begin
      bAct <= bIn;
      aAct <= aIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kCnt <= '0;
    end else if (pcTerm) begin
      kCnt <= lastPeriod ? '0 : kCnt + 1'b1;
    end
  end

  // R8
  held_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bAct >= B_W'(MIN_B)) && (aActWide < bAct) && (aActWide < B_W'(PRE_VAL)));

  // R9
  mid_cycle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !atStart |=> ($stable(bAct) && $stable(aAct)));

  // R2
  period_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    kCnt < bAct);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int B_W     = 11,
  parameter int A_W     = 7,
  parameter int PRE_LOG = 6,
  parameter int MIN_B   = 3,
  parameter int DEF_B   = 3,
  parameter int DEF_A   = 0
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [B_W-1:0] bIn,
  input  logic [A_W-1:0] aIn,
  output logic           divPulse,
  output logic           cfgBad
);
  divStrobe_t strobe;
  logic       pcTerm;
  logic       pcZero;

  swdiv_control #(
    .B_W(B_W), .A_W(A_W), .PRE_LOG(PRE_LOG),
    .MIN_B(MIN_B), .DEF_B(DEF_B), .DEF_A(DEF_A)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .bIn(bIn), .aIn(aIn),
    .pcTerm(pcTerm), .pcZero(pcZero), .strobe(strobe), .cfgBad(cfgBad)
  );

  swdiv_datapath #(.PRE_LOG(PRE_LOG)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcTerm(pcTerm), .pcZero(pcZero), .divPulse(divPulse)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> !divPulse);
endmodule

// File: tb/sim_swallow_divider.sv
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] bIn = 11'd1;
  logic [6:0]  aIn = 7'd0;
  logic        divPulse;
  logic        cfgBad;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;   // 50 MHz

  swallow_divider u0 (
    .clk(clk), .rstN(rstN), .bIn(bIn), .aIn(aIn),
    .divPulse(divPulse), .cfgBad(cfgBad)
  );

  typedef struct packed {
    logic [10:0] b;
    logic [6:0]  a;
    logic        bad;
    logic [31:0] n;
  } vec_t;

  // n: expected pulse spacing (held ratio for flagged settings)
  localparam vec_t VEC [10] = '{
    '{b: 11'd3,   a: 7'd0,  bad: 1'b0, n: 32'd192},
    '{b: 11'd3,   a: 7'd2,  bad: 1'b0, n: 32'd194},
    '{b: 11'd5,   a: 7'd4,  bad: 1'b0, n: 32'd324},
    '{b: 11'd2,   a: 7'd0,  bad: 1'b1, n: 32'd324},
    '{b: 11'd3,   a: 7'd3,  bad: 1'b1, n: 32'd324},
    '{b: 11'd100, a: 7'd64, bad: 1'b1, n: 32'd324},
    '{b: 11'd64,  a: 7'd63, bad: 1'b0, n: 32'd4159},
    '{b: 11'd99,  a: 7'd12, bad: 1'b0, n: 32'd6348},
    '{b: 11'd0,   a: 7'd0,  bad: 1'b1, n: 32'd6348},
    '{b: 11'd260, a: 7'd32, bad: 1'b0, n: 32'd16672}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!divPulse);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R1, R5: reset state with B=1
    repeat (3) @(negedge clk);
    chk("R1 divPulse in reset", 32'(divPulse), 32'd0);
    chk("R5 cfgBad for B=1", 32'(cfgBad), 32'd1);

    // R10: illegal setting at release, default 192 used
    rstN = 1'b1;
    measure(n);
    chk("R10 first interval default", n, 32'd192);
    measure(n);
    chk("R10 second interval default", n, 32'd192);

    // R4: reset with legal B=5 A=4
    @(negedge clk);
    rstN = 1'b0;
    bIn = 11'd5; aIn = 7'd4;
    repeat (2) @(negedge clk);
    chk("R1 divPulse in reset", 32'(divPulse), 32'd0);
    rstN = 1'b1;
    measure(n);
    chk("R4 first pulse after release", n, 32'd324);
    @(negedge clk);
    chk("R3 pulse one clock wide", 32'(divPulse), 32'd0);

    // vector walk
    for (int i = 0; i < 10; i++) begin
      bIn = VEC[i].b; aIn = VEC[i].a;
      #1;
      chk(VEC[i].bad ? "R5/R6/R7 cfgBad set" : "R7 cfgBad clear",
          32'(cfgBad), 32'(VEC[i].bad));
      waitPulse();
      measure(n);
      chk(VEC[i].bad ? "R8 held ratio" : "R2 pulse spacing", n, VEC[i].n);
      @(negedge clk);
      chk("R3 pulse one clock wide", 32'(divPulse), 32'd0);
    end

    // R9: change inputs inside a running cycle
    bIn = 11'd64; aIn = 7'd63;
    waitPulse();
    n = 0;
    repeat (50) begin @(negedge clk); n++; end
    bIn = 11'd4; aIn = 7'd1;
    do begin @(negedge clk); n++; end while (!divPulse);
    chk("R9 mid-cycle change ignored", n, 32'd4159);
    measure(n);
    chk("R9 change applied next cycle", n, 32'd257);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule